// File: doc/BRIEF.md
# Quad Double-Buffered DAC Code Register Front End

This block is the digital front end of a four-channel, 8-bit parallel-input converter. A host puts a code on an 8-bit bus, picks a channel with a 2-bit select and pulls an active-low write strobe. That stores the code in the channel's first-stage holding register. A separate active-low load strobe moves all four holding registers into the second-stage output registers together. The output registers drive the converter codes, so all four analog outputs can change at the same instant.

The model is clocked. Both strobes, the select and the bus are sampled on every rising clock edge. A stage that is open at an edge shows its new value at its register output after that edge. If the load strobe is tied low, the block acts as a single-buffered converter: a write reaches the output one cycle after it reaches the holding register. If both strobes are low, bus data flows through the selected channel to its output. The strobes are plain level controls, so there is no valid/ready handshake and no back-pressure. Every strobed cycle is accepted.

Top module: `dacq_frontend`

## Requirements
- R1: A synchronous active-low reset clears all four holding registers, all four output codes and the load flag to zero.
- R2: The channel select value 0, 1, 2 and 3 addresses channel A, B, C and D. Channel k's output code sits in `code_out[8k+7:8k]`.
- R3: At a clock edge where `wr_n` is low, the addressed holding register takes `data_in`.
- R4: A holding register that is not addressed, or that sees `wr_n` high, never changes, whatever the level of `ld_n`.
- R5: At a clock edge where `ld_n` is low, all four output codes take the values their holding registers had before that edge, all in the same cycle.
- R6: While `ld_n` is high, all output codes hold. While both strobes are high, every register in the block holds.
- R7: If both strobes stay low, a bus value shows on the addressed output two edges after it is applied. If `ld_n` stays low, every write reaches its output one edge after it enters the holding register.
- R8: `load_open` is high in the cycle after an edge where `ld_n` was low, and low after an edge where it was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All sampling happens on the rising edge. |
| rst_n | input | 1 | Synchronous reset, active low. Acts as the power-up preset. |
| data_in | input | 8 | Code bus written into the selected holding register. |
| chan_sel | input | 2 | Channel select: 0=A, 1=B, 2=C, 3=D. |
| wr_n | input | 1 | Write strobe, active low. |
| ld_n | input | 1 | Global load strobe, active low. |
| code_out | output | 32 | The four output codes, with channel A in the lowest byte. |
| load_open | output | 1 | High while the load stage was open at the last edge. |

## Verification
The assertions assume that the strobes, select and bus are stable and known at each rising edge, and that reset is held for at least one edge before any checked traffic. The bench meets this by changing every input only on the falling clock edge. It also keeps the scoreboard empty across each reset pulse, so no expected item spans a reset. The stimulus covers buffered writes followed by one load pulse, idle hold periods, flow-through with both strobes held low, single-buffered use with the load strobe tied low, and writes to every channel. The writes to each channel also check that the other three channels keep their values.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int unsigned CHANNELS   = 4;
  localparam int unsigned CODE_WIDTH = 8;

  typedef enum logic [1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2,
    CH_D = 2'd3
  } chan_e;
endpackage

// File: rtl/dacq_addr_decode.sv
module dacq_addr_decode #(
  parameter int unsigned NCH = 4,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  sel,
  input  logic           strobe_n,
  output logic [NCH-1:0] en
);
  always_comb begin
    en = '0;
    for (int i = 0; i < NCH; i++) begin
      en[i] = !strobe_n && (sel == AW'(i));
    end
  end
endmodule

// File: rtl/dacq_stage.sv
module dacq_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  // R6: a closed stage keeps its value
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/dacq_frontend.sv
module dacq_frontend
  import dacq_pkg::*;
#(
  parameter int unsigned NCH = CHANNELS,
  parameter int unsigned DW  = CODE_WIDTH,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned BW = NCH * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] chan_sel,
  input  logic          wr_n,
  input  logic          ld_n,
  output logic [BW-1:0] code_out,
  output logic          load_open
);
  logic [NCH-1:0] wr_en;
  logic [BW-1:0]  hold_q;
  logic           load_en;

  assign load_en = !ld_n;

  dacq_addr_decode #(.NCH(NCH)) u_decode (
    .sel      (chan_sel),
    .strobe_n (wr_n),
    .en       (wr_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dacq_stage #(.DW(DW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wr_en[g]),
      .d     (data_in),
      .q     (hold_q[g*DW +: DW])
    );

    dacq_stage #(.DW(DW)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (load_en),
      .d     (hold_q[g*DW +: DW]),
      .q     (code_out[g*DW +: DW])
    );

    // R3: the addressed holding register captures the bus
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && chan_sel == AW'(g)) |=> hold_q[g*DW +: DW] == $past(data_in));

    // R4: unaddressed holding registers stay put
    a_r4_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n || chan_sel != AW'(g)) |=> $stable(hold_q[g*DW +: DW]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) load_open <= 1'b0;
    else        load_open <= load_en;
  end

  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (code_out == '0 && load_open == 1'b0));

  // R2: at most one channel written, exactly one when the strobe is low
  a_r2_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en) && (wr_n || $countones(wr_en) == 1));

  // R5: a load copies all holding registers at once
  a_r5_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> code_out == $past(hold_q));

  // R6: output codes hold while the load strobe is high
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(code_out));

  // R8: flag mirrors the load strobe of the previous edge
  a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> load_open == !$past(ld_n));
endmodule

// File: tb/test_dacq_frontend.sv
module test_dacq_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 8;

  typedef struct {
    logic [NCH*DW-1:0] code;
    logic              flag;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DW-1:0]     data_in = '0;
  logic [1:0]        chan_sel = '0;
  logic              wr_n = 1'b1;
  logic              ld_n = 1'b1;
  logic [NCH*DW-1:0] code_out;
  logic              load_open;

  int n_tests = 0;
  int n_fail  = 0;

  logic [DW-1:0] m_hold [NCH];
  logic [DW-1:0] m_out  [NCH];
  exp_t          sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dacq_frontend i_dacq_frontend (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .chan_sel  (chan_sel),
    .wr_n      (wr_n),
    .ld_n      (ld_n),
    .code_out  (code_out),
    .load_open (load_open)
  );

  function automatic logic [NCH*DW-1:0] pack_out();
    logic [NCH*DW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*DW +: DW] = m_out[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_hold[i] = '0;
      m_out[i]  = '0;
    end
  endtask

  // driver: one clock cycle of stimulus, expected result pushed to scoreboard
  task automatic step(input logic w, input logic l, input logic [1:0] s,
                      input logic [DW-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_n = w; ld_n = l; chan_sel = s; data_in = d;
    if (!l) for (int i = 0; i < NCH; i++) m_out[i] = m_hold[i];
    if (!w) m_hold[s] = d;
    e.code = pack_out();
    e.flag = !l;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compares one scoreboard item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (code_out !== e.code || load_open !== e.flag) begin
          n_fail++;
          $display("FAIL %s: actual code=%h flag=%b expected code=%h flag=%b",
                   e.tag, code_out, load_open, e.code, e.flag);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    n_tests++;
    if (code_out !== '0 || load_open !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual code=%h flag=%b expected code=0 flag=0",
               tag, code_out, load_open);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    // R1: reset with strobes active must still clear everything
    wr_n = 1'b0; ld_n = 1'b0; data_in = 8'hFF;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; ld_n = 1'b1;
    @(negedge clk);
    check_reset("R1 power-up");
    rst_n = 1'b1;

    // R2 R3 R4 R6: buffered writes, outputs stay at zero
    step(1'b0, 1'b1, 2'd0, 8'h11, "R2 R3 R6 write A buffered");
    step(1'b0, 1'b1, 2'd1, 8'h22, "R2 R3 R6 write B buffered");
    step(1'b0, 1'b1, 2'd2, 8'h33, "R2 R3 R6 write C buffered");
    step(1'b0, 1'b1, 2'd3, 8'h44, "R2 R3 R6 write D buffered");
    step(1'b1, 1'b1, 2'd0, 8'hEE, "R6 idle both high");
    // R5: one load pulse updates all four in one cycle
    step(1'b1, 1'b0, 2'd0, 8'h00, "R5 R8 load all");
    step(1'b1, 1'b1, 2'd2, 8'h99, "R6 R8 hold after load");
    step(1'b1, 1'b1, 2'd1, 8'h77, "R6 bus ignored");
    // R4: overwrite C only, then load; A B D must keep their codes
    step(1'b0, 1'b1, 2'd2, 8'hC5, "R4 write C only");
    step(1'b1, 1'b0, 2'd0, 8'h00, "R4 R5 load after C");
    // R7: flow-through with both strobes low on channel B
    step(1'b0, 1'b0, 2'd1, 8'hB7, "R7 flow B first edge");
    step(1'b0, 1'b0, 2'd1, 8'hB7, "R7 flow B second edge");
    step(1'b0, 1'b0, 2'd3, 8'h5A, "R4 R7 flow D, B stays");
    step(1'b1, 1'b1, 2'd3, 8'h00, "R6 settle");
    // R7: ld_n tied low, single-buffered writes to each channel
    for (int k = 0; k < 12; k++) begin
      step(1'b0, 1'b0, 2'(k % 4), 8'(k * 37 + 5), "R7 single-buffered write");
      step(1'b1, 1'b0, 2'(k % 4), 8'hA5, "R4 R7 single-buffered follow");
    end
    // R4: writes with ld_n high never disturb other channels
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b1, 2'(3 - k % 4), 8'(k * 91 + 3), "R4 mixed buffered");
    step(1'b1, 1'b0, 2'd0, 8'h00, "R5 final load");
    step(1'b1, 1'b1, 2'd0, 8'h00, "R8 flag drops");
    drain();

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_reset("R1 mid-run reset");
    rst_n = 1'b1;
    step(1'b1, 1'b0, 2'd0, 8'h00, "R1 R5 load after reset");
    drain();
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule